// File: doc/BRIEF.md
# Two-Way Byte Command Mailbox

This block holds one command byte in each direction between a host register port and a local processor register port. Both ports share one clock. Each side writes a byte for the other side and reads the byte that the other side left for it. Two independent one-byte channels carry the traffic, so a byte travelling towards the host is never disturbed by a byte travelling towards the local processor.

Each channel is a two-state machine with the states `CH_EMPTY` and `CH_FULL`. From `CH_EMPTY`, a write takes the transition DEPOSIT to `CH_FULL`. In `CH_FULL`, a further write takes REFILL: the held byte is replaced and the state stays `CH_FULL`. A read with no write in the same cycle takes DRAIN back to `CH_EMPTY`.

Each direction also has an interrupt machine with the states `IRQ_IDLE` and `IRQ_PEND`. A deposit takes ARM from `IRQ_IDLE` to `IRQ_PEND`. A read of the full channel takes ACK from `IRQ_PEND` back to `IRQ_IDLE`. Dropping the enable takes MASK from `IRQ_PEND` to `IRQ_IDLE`. The interrupt towards the local processor is always enabled. The interrupt towards the host is gated by a host-controlled enable.

Each side polls its flag pair, or waits for its interrupt, before it reads or writes.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, both empty flags are 1, both full flags are 0, both interrupts are 0 and both read-data outputs are 0x00.
- R2: A host write makes `h2l_full` 1 and `h2l_empty` 0 on the next cycle, and `loc_rdata` shows the written byte.
- R3: A local read while `h2l_full` is 1, with no host write in that cycle, makes `h2l_full` 0 and `h2l_empty` 1 on the next cycle.
- R4: A local write makes `l2h_full` 1 and `l2h_empty` 0 on the next cycle, and `host_rdata` shows the written byte.
- R5: A host read while `l2h_full` is 1, with no local write in that cycle, makes `l2h_full` 0 and `l2h_empty` 1 on the next cycle.
- R6: `loc_irq` becomes 1 in the cycle after a host write and returns to 0 in the cycle after a local read that drains the channel.
- R7: `host_irq` becomes 1 after a local write only when `host_irq_en` is 1 in the write cycle. It clears after a draining host read, and it is 0 in any cycle where `host_irq_en` is 0.
- R8: The two channels are independent. A write or read on one channel leaves the other channel's flags and held byte unchanged, and both channels may be written in the same cycle.
- R9: A write into a full channel replaces the held byte and leaves the flags full.
- R10: A read and a write on the same full channel in one cycle leave the channel full with the new byte, and its interrupt stays asserted.
- R11: A read of an empty channel changes no flag, no interrupt and no held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_wdata | input | 8 | Byte the host deposits |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_rdata | output | 8 | Byte waiting for the host |
| host_irq_en | input | 1 | Enables the host interrupt |
| loc_wr | input | 1 | Single-cycle local write strobe |
| loc_wdata | input | 8 | Byte the local side deposits |
| loc_rd | input | 1 | Single-cycle local read strobe |
| loc_rdata | output | 8 | Byte waiting for the local side |
| h2l_empty | output | 1 | Host-to-local channel empty (host view) |
| h2l_full | output | 1 | Host-to-local channel full (local view) |
| l2h_full | output | 1 | Local-to-host channel full (host view) |
| l2h_empty | output | 1 | Local-to-host channel empty (local view) |
| loc_irq | output | 1 | Interrupt to the local processor |
| host_irq | output | 1 | Enable-gated interrupt to the host |

## Verification
A write and a read of the same channel can land in the same cycle. A deposit on one channel can also coincide with a deposit or a drain on the other channel. The vector table drives such pairs on purpose: both writes together, a local read together with a new host write, and a host read together with a new local write. Each pair is judged on the following cycle by the flags, the held bytes and both interrupts. The write must win on the shared channel, and the other channel must be untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        CH_EMPTY = 1'b0,
        CH_FULL  = 1'b1
    } chan_state_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              empty,
    output logic              drained
);
    chan_state_e       state_q, state_d;
    logic [DATA_W-1:0] hold_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: DEPOSIT, REFILL, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_EMPTY: if (wr) state_d = CH_FULL;                 // DEPOSIT
            CH_FULL: begin
                if (wr)      state_d = CH_FULL;                  // REFILL
                else if (rd) state_d = CH_EMPTY;                 // DRAIN
            end
            default: state_d = CH_EMPTY;
        endcase
    end

    // holding register, written on every write
    always_ff @(posedge clk) begin
        if (!rst_n)  hold_q <= '0;
        else if (wr) hold_q <= wdata;
    end

    // outputs
    always_comb begin
        full    = (state_q == CH_FULL);
        empty   = (state_q == CH_EMPTY);
        drained = rd && (state_q == CH_FULL);
        rdata   = hold_q;
    end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ARM, ACK, MASK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (set && en) state_d = IRQ_PEND;         // ARM
            IRQ_PEND: begin
                if (!en)                state_d = IRQ_IDLE;      // MASK
                else if (clr && !set)   state_d = IRQ_IDLE;      // ACK
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_PEND) && en;
    end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              host_irq_en,
    input  logic              loc_wr,
    input  logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_rd,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              h2l_empty,
    output logic              h2l_full,
    output logic              l2h_full,
    output logic              l2h_empty,
    output logic              loc_irq,
    output logic              host_irq
);
    logic h2l_drained, l2h_drained;

    // host-to-local channel
    mbx_channel #(.DATA_W(DATA_W)) u_h2l (
        .clk(clk), .rst_n(rst_n),
        .wr(host_wr), .wdata(host_wdata), .rd(loc_rd),
        .rdata(loc_rdata), .full(h2l_full), .empty(h2l_empty),
        .drained(h2l_drained)
    );

    // local-to-host channel
    mbx_channel #(.DATA_W(DATA_W)) u_l2h (
        .clk(clk), .rst_n(rst_n),
        .wr(loc_wr), .wdata(loc_wdata), .rd(host_rd),
        .rdata(host_rdata), .full(l2h_full), .empty(l2h_empty),
        .drained(l2h_drained)
    );

    mbx_irq u_loc_irq (
        .clk(clk), .rst_n(rst_n),
        .set(host_wr), .clr(h2l_drained), .en(1'b1), .irq(loc_irq)
    );

    mbx_irq u_host_irq (
        .clk(clk), .rst_n(rst_n),
        .set(loc_wr), .clr(l2h_drained), .en(host_irq_en), .irq(host_irq)
    );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_irq_en,
    input logic              loc_wr,
    input logic [DATA_W-1:0] loc_wdata,
    input logic              loc_rd,
    input logic [DATA_W-1:0] loc_rdata,
    input logic              h2l_empty,
    input logic              h2l_full,
    input logic              l2h_full,
    input logic              l2h_empty,
    input logic              loc_irq,
    input logic              host_irq
);
    a_r2_host_deposit: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (h2l_full && !h2l_empty && loc_rdata == $past(host_wdata)));

    a_r3_local_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd && h2l_full && !host_wr) |=> (h2l_empty && !h2l_full));

    a_r4_local_deposit: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr |=> (l2h_full && !l2h_empty && host_rdata == $past(loc_wdata)));

    a_r5_host_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && l2h_full && !loc_wr) |=> (l2h_empty && !l2h_full));

    a_r6_loc_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> loc_irq);

    a_r6_loc_irq_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd && h2l_full && !host_wr) |=> !loc_irq);

    a_r7_host_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !host_irq_en |-> !host_irq);

    a_r7_host_irq_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && l2h_full && !loc_wr) |=> !host_irq);

    a_r8_h2l_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_wr |=> $stable(host_rdata));

    a_r11_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd && h2l_empty && !host_wr) |=> (h2l_empty && !loc_irq && $stable(loc_rdata)));
endmodule

bind cmd_mailbox mbx_checker #(.DATA_W(DATA_W)) u_mbx_checker (.*);

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_wr, host_rd, host_irq_en, loc_wr, loc_rd;
    logic [7:0] host_wdata, loc_wdata, host_rdata, loc_rdata;
    logic       h2l_empty, h2l_full, l2h_full, l2h_empty, loc_irq, host_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    cmd_mailbox u_cmd_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_irq_en(host_irq_en),
        .loc_wr(loc_wr), .loc_wdata(loc_wdata), .loc_rd(loc_rd),
        .loc_rdata(loc_rdata),
        .h2l_empty(h2l_empty), .h2l_full(h2l_full),
        .l2h_full(l2h_full), .l2h_empty(l2h_empty),
        .loc_irq(loc_irq), .host_irq(host_irq)
    );

    typedef struct packed {
        logic       hwr;
        logic [7:0] hdat;
        logic       hrd;
        logic       lwr;
        logic [7:0] ldat;
        logic       lrd;
        logic       en;
        logic       x_h2l;
        logic       x_l2h;
        logic       x_lirq;
        logic       x_hirq;
        logic [7:0] x_lrdata;
        logic [7:0] x_hrdata;
    } vec_t;

    localparam int NVEC = 12;
    // rows: R2/R6, R9, R3, R11, R4/R7/R8, R5, R7 masked, R7 idle, R8 both, R10 local, R10 host, drain both
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'hAA, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hAA, 8'h00},
        '{1'b1, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h55, 8'h3C},
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h3C},
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 8'hC3},
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 8'hC3},
        '{1'b1, 8'h12, 1'b0, 1'b1, 8'h34, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h12, 8'h34},
        '{1'b1, 8'h77, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h77, 8'h34},
        '{1'b0, 8'h00, 1'b1, 1'b1, 8'h99, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h77, 8'h99},
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 8'h99}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        host_wr = 1'b0; host_rd = 1'b0; loc_wr = 1'b0; loc_rd = 1'b0;
        host_wdata = 8'h00; loc_wdata = 8'h00;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_flags(input string req, input logic h2l, input logic l2h);
        check(req, {h2l_full, h2l_empty}, {h2l, !h2l});
        check(req, {l2h_full, l2h_empty}, {l2h, !l2h});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        host_irq_en = 1'b1;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check_flags("R1", 1'b0, 1'b0);
        check("R1 irqs", {loc_irq, host_irq}, 2'b00);
        check("R1 data", {loc_rdata, host_rdata}, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            host_wr = VEC[i].hwr; host_wdata = VEC[i].hdat; host_rd = VEC[i].hrd;
            loc_wr = VEC[i].lwr; loc_wdata = VEC[i].ldat; loc_rd = VEC[i].lrd;
            host_irq_en = VEC[i].en;
            tick();
            idle_inputs();
            check($sformatf("R2/R3 h2l row %0d", i), {h2l_full, h2l_empty}, {VEC[i].x_h2l, !VEC[i].x_h2l});
            check($sformatf("R4/R5 l2h row %0d", i), {l2h_full, l2h_empty}, {VEC[i].x_l2h, !VEC[i].x_l2h});
            check($sformatf("R6 loc_irq row %0d", i), loc_irq, VEC[i].x_lirq);
            check($sformatf("R7 host_irq row %0d", i), host_irq, VEC[i].x_hirq);
            check($sformatf("R8/R9/R10 loc_rdata row %0d", i), loc_rdata, VEC[i].x_lrdata);
            check($sformatf("R8/R9/R10 host_rdata row %0d", i), host_rdata, VEC[i].x_hrdata);
        end

        // R7: dropping enable masks a pending host interrupt at once
        host_irq_en = 1'b1;
        loc_wr = 1'b1; loc_wdata = 8'h5A;
        tick();
        idle_inputs();
        check("R7 armed", host_irq, 1'b1);
        host_irq_en = 1'b0;
        #1;
        check("R7 masked", host_irq, 1'b0);
        tick();
        host_irq_en = 1'b1;
        #1;
        check("R7 stays cleared", host_irq, 1'b0);
        check("R8 l2h still full", l2h_full, 1'b1);

        // R11: host read of empty channel after draining
        host_rd = 1'b1; tick(); idle_inputs();
        check("R5 drain", l2h_empty, 1'b1);
        host_rd = 1'b1; tick(); idle_inputs();
        check("R11 empty read flags", {l2h_full, l2h_empty}, 2'b01);
        check("R11 empty read data", host_rdata, 8'h5A);

        // R1: reset while both channels hold bytes
        host_wr = 1'b1; host_wdata = 8'hE1; loc_wr = 1'b1; loc_wdata = 8'hE2;
        tick(); idle_inputs();
        check_flags("R8 both full", 1'b1, 1'b1);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check_flags("R1 after reset", 1'b0, 1'b0);
        check("R1 irqs after reset", {loc_irq, host_irq}, 2'b00);
        check("R1 data after reset", {loc_rdata, host_rdata}, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule